// File: doc/BRIEF.md
# Receive Frame FIFO Forwarding Controller

This block sits between the receive side of an Ethernet MAC and the read port of a receive DMA engine. Words of incoming frames are written into a word FIFO as they arrive; at the end of every frame a small status record (MAC-level error, payload checksum error, overflow, position of the last word) is queued beside it. A read-side controller looks at the frame at the head of the FIFO and decides, before any word of it leaves, whether it is streamed to the reader, discarded because of its status, or flushed because no receive buffer is free.

Two forwarding modes exist. In store-and-forward mode a frame is released only once its last word is in the FIFO, so every frame can be judged before it is read. In cut-through mode a frame is released as soon as enough of it is buffered to pass a programmable start threshold; a frame released that way can no longer be discarded, so its error status travels with its last word instead. A discarded or flushed frame leaves in one cycle: the read pointer jumps past its last word, and the reader never sees any of it. When the FIFO fills in the middle of a frame, the remainder of that frame is thrown away, the frame is tagged as overflowed and later discarded, and a single overflow pulse is raised.

Top module: `rxf_fwd_ctrl`

## Requirements
- R1: With `cfg_store_fwd` high, no word of a frame appears on the read port before the write of that frame's last word; the threshold code has no effect.
- R2: With `cfg_store_fwd` low, a frame that is still being written starts on the read port once its buffered word count reaches 8 × (`cfg_thresh` + 1) words (code 0..3 selects 32, 64, 96, 128 bytes), within two cycles of that count being reached.
- R3: With `cfg_keep_csum` high, a frame whose only flagged fault is `in_csum_err` is forwarded whole; a frame that also carries `in_mac_err` is still discarded when `cfg_fwd_err` is low.
- R4: With `cfg_keep_csum` and `cfg_fwd_err` low, a complete frame with any error flag is discarded: `drop_pulse` is high for one cycle, no word of it appears on the read port, and later frames are delivered intact.
- R5: With `cfg_fwd_err` high, a frame carrying MAC or checksum errors is forwarded, and `out_err` is high on its last word only.
- R6: With `buf_avail` low and `cfg_no_flush` low, a complete good frame at the head is flushed: `flush_pulse` is high for one cycle and none of its words appear.
- R7: With `cfg_no_flush` high, `buf_avail` low never flushes; the frame waits and is delivered whole once `buf_avail` rises.
- R8: After reset `out_valid`, `ovf_pulse`, `drop_pulse` and `flush_pulse` are all low.
- R9: A frame already released in cut-through mode is never discarded; it is delivered whole and its error shows as `out_err` on its last word.
- R10: When a frame's data word finds the FIFO one entry short of full, the rest of the frame's data is dropped, `ovf_pulse` is high for exactly one cycle, the frame is later discarded with `drop_pulse`, and the next frame is delivered intact.
- R11: Delivered words keep their order and data; `out_sof` marks the first word, `out_eof` the last, and `out_nbytes` on the last word repeats the value written with it (0 meaning all four bytes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_store_fwd | input | 1 | 1: store-and-forward, 0: cut-through |
| cfg_thresh | input | 2 | Cut-through start threshold code |
| cfg_keep_csum | input | 1 | Keep frames whose only fault is a payload checksum error |
| cfg_fwd_err | input | 1 | Forward frames with errors instead of discarding them |
| cfg_no_flush | input | 1 | Wait rather than flush when no receive buffer is free |
| buf_avail | input | 1 | A receive buffer is available for the head frame |
| in_valid | input | 1 | Write word valid (no backpressure) |
| in_data | input | 32 | Write data word |
| in_sof | input | 1 | First word of a frame |
| in_eof | input | 1 | Last word of a frame |
| in_nbytes | input | 2 | Valid bytes in the last word, 0 meaning 4 |
| in_mac_err | input | 1 | MAC-level error, sampled with the last word |
| in_csum_err | input | 1 | Payload checksum error, sampled with the last word |
| out_valid | output | 1 | Read word valid |
| out_ready | input | 1 | Reader accepts the word |
| out_data | output | 32 | Read data word |
| out_sof | output | 1 | First word of the frame |
| out_eof | output | 1 | Last word of the frame |
| out_nbytes | output | 2 | Valid bytes in the last word |
| out_err | output | 1 | Frame error status, on the last word |
| ovf_pulse | output | 1 | One-cycle pulse per overflowed frame |
| drop_pulse | output | 1 | One-cycle pulse per discarded frame |
| flush_pulse | output | 1 | One-cycle pulse per flushed frame |

## Verification
On every cycle the assertions watch the release rules: a store-and-forward frame is never started while its status is missing, a cut-through start never precedes the threshold, a discarded frame never drives the read port, the flush inhibit is never broken, error status only rides on a last word, and a frame's last word always finds a free slot after an overflow. Whether the right frames reach the reader with intact data, the right ones vanish, the start cycle lands close to the threshold, and a waiting frame resumes once a buffer appears can only be shown by the bench's directed frame sequences.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef struct packed {
    logic [31:0] data;
    logic        sof;
    logic        eof;
    logic [1:0]  nbytes;
  } rxf_word_t;

  typedef struct packed {
    logic ovf;
    logic csum;
    logic mac;
  } rxf_stat_t;

  localparam int unsigned WORD_W = $bits(rxf_word_t);
  localparam int unsigned STAT_W = $bits(rxf_stat_t);

  // words needed before a cut-through start: 32 bytes per code step
  function automatic logic [31:0] thr_words(input logic [1:0] code);
    return (32'(code) + 32'd1) << 3;
  endfunction

  // discard verdict for a complete frame at the head
  function automatic logic frame_bad(input rxf_stat_t s, input logic keep_csum,
                                     input logic fwd_err);
    if (s.ovf) return 1'b1;
    if (fwd_err) return 1'b0;
    if (s.mac) return 1'b1;
    if (s.csum) return !keep_csum;
    return 1'b0;
  endfunction

endpackage

// File: rtl/rxf_ram.sv
module rxf_ram #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxf_wr_ctl.sv
module rxf_wr_ctl
  import rxf_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     in_data,
  input  logic            in_sof,
  input  logic            in_eof,
  input  logic [1:0]      in_nbytes,
  input  logic            in_mac_err,
  input  logic            in_csum_err,
  input  logic [AW:0]     used,
  output logic            d_we,
  output rxf_word_t       d_wdata,
  output logic            s_we,
  output rxf_stat_t       s_flags,
  output logic [AW:0]     wr_ptr,
  output logic [AW:0]     st_wptr,
  output logic            ovf_pulse
);
  localparam int unsigned DEPTH = 1 << AW;

  logic ovf_q, any_q;
  logic ovf_c, any_c;
  logic room_data, room_eof;
  logic set_ovf, lost_ev;

  always_comb begin
    ovf_c     = in_sof ? 1'b0 : ovf_q;
    any_c     = in_sof ? 1'b0 : any_q;
    room_data = used < (AW+1)'(DEPTH - 1);
    room_eof  = used < (AW+1)'(DEPTH);
    d_we      = 1'b0;
    set_ovf   = 1'b0;
    lost_ev   = 1'b0;
    if (in_valid) begin
      if (in_eof) begin
        if (room_eof) d_we = 1'b1;
        else          lost_ev = 1'b1;
      end else if (!ovf_c) begin
        if (room_data) d_we = 1'b1;
        else           set_ovf = 1'b1;
      end
    end
  end

  assign s_we      = d_we && in_eof;
  assign s_flags   = '{ovf: ovf_c, csum: in_csum_err, mac: in_mac_err};
  assign d_wdata   = '{data: in_data, sof: !any_c, eof: in_eof, nbytes: in_nbytes};
  assign ovf_pulse = set_ovf || (lost_ev && !ovf_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q   <= 1'b0;
      any_q   <= 1'b0;
      wr_ptr  <= '0;
      st_wptr <= '0;
    end else begin
      if (in_valid) begin
        ovf_q <= in_eof ? 1'b0 : (ovf_c || set_ovf);
        any_q <= in_eof ? 1'b0 : (any_c || d_we);
      end
      if (d_we) wr_ptr  <= wr_ptr + 1'b1;
      if (s_we) st_wptr <= st_wptr + 1'b1;
    end
  end

  AST_EOF_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_eof && any_c |-> room_eof); // R10
  AST_OVF_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse); // R10
endmodule

// File: rtl/rxf_rd_ctl.sv
module rxf_rd_ctl
  import rxf_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_store_fwd,
  input  logic [1:0]      cfg_thresh,
  input  logic            cfg_keep_csum,
  input  logic            cfg_fwd_err,
  input  logic            cfg_no_flush,
  input  logic            buf_avail,
  input  logic [AW:0]     wr_ptr,
  input  logic [AW:0]     st_wptr,
  input  rxf_word_t       hd_word,
  input  rxf_stat_t       hd_flags,
  input  logic [AW:0]     hd_eofp,
  input  logic            out_ready,
  output logic [AW:0]     rd_ptr,
  output logic [AW:0]     st_rptr,
  output logic            out_valid,
  output logic [31:0]     out_data,
  output logic            out_sof,
  output logic            out_eof,
  output logic [1:0]      out_nbytes,
  output logic            out_err,
  output logic            drop_pulse,
  output logic            flush_pulse
);
  typedef enum logic {S_HEAD, S_SEND} rd_state_e;

  rd_state_e   state;
  logic [AW:0] words;
  logic        st_avail, bad;
  logic        go_send, drop_ev, flush_ev, skip_ev, pop, last_pop;

  assign words    = wr_ptr - rd_ptr;
  assign st_avail = st_wptr != st_rptr;
  assign bad      = frame_bad(hd_flags, cfg_keep_csum, cfg_fwd_err);

  always_comb begin
    go_send  = 1'b0;
    drop_ev  = 1'b0;
    flush_ev = 1'b0;
    if (state == S_HEAD) begin
      if (st_avail) begin
        if (bad)             drop_ev  = 1'b1;
        else if (!buf_avail) flush_ev = !cfg_no_flush;
        else                 go_send  = 1'b1;
      end else if (!cfg_store_fwd && buf_avail &&
                   32'(words) >= thr_words(cfg_thresh)) begin
        go_send = 1'b1;
      end
    end
  end

  assign skip_ev     = drop_ev || flush_ev;
  assign out_valid   = (state == S_SEND) && (words != '0);
  assign pop         = out_valid && out_ready;
  assign last_pop    = pop && hd_word.eof;
  assign out_data    = hd_word.data;
  assign out_sof     = out_valid && hd_word.sof;
  assign out_eof     = out_valid && hd_word.eof;
  assign out_nbytes  = hd_word.nbytes;
  assign out_err     = out_eof && (hd_flags.mac || hd_flags.csum || hd_flags.ovf);
  assign drop_pulse  = drop_ev;
  assign flush_pulse = flush_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_HEAD;
      rd_ptr  <= '0;
      st_rptr <= '0;
    end else begin
      if (skip_ev) begin
        rd_ptr  <= hd_eofp + 1'b1;
        st_rptr <= st_rptr + 1'b1;
      end else if (pop) begin
        rd_ptr <= rd_ptr + 1'b1;
        if (last_pop) st_rptr <= st_rptr + 1'b1;
      end
      if (go_send)       state <= S_SEND;
      else if (last_pop) state <= S_HEAD;
    end
  end

  AST_SF_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof && cfg_store_fwd |-> st_avail); // R1
  AST_CT_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && out_sof && !st_avail |->
      !cfg_store_fwd && 32'(words) >= thr_words(cfg_thresh)); // R2
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    skip_ev |-> !out_valid); // R4
  AST_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_no_flush |-> !flush_pulse); // R7
  AST_ERR_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_eof); // R5
endmodule

// File: rtl/rxf_fwd_ctrl.sv
module rxf_fwd_ctrl
  import rxf_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_store_fwd,
  input  logic [1:0]  cfg_thresh,
  input  logic        cfg_keep_csum,
  input  logic        cfg_fwd_err,
  input  logic        cfg_no_flush,
  input  logic        buf_avail,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [1:0]  in_nbytes,
  input  logic        in_mac_err,
  input  logic        in_csum_err,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        out_sof,
  output logic        out_eof,
  output logic [1:0]  out_nbytes,
  output logic        out_err,
  output logic        ovf_pulse,
  output logic        drop_pulse,
  output logic        flush_pulse
);
  localparam int unsigned SREC_W = STAT_W + AW + 1;

  logic [AW:0]       wr_ptr, rd_ptr, st_wptr, st_rptr, used;
  logic              d_we, s_we;
  rxf_word_t         d_wdata, hd_word;
  rxf_stat_t         s_flags, hd_flags;
  logic [AW:0]       hd_eofp;
  logic [SREC_W-1:0] s_wrec, s_rrec;
  logic [WORD_W-1:0] d_rraw;

  assign used     = wr_ptr - rd_ptr;
  assign s_wrec   = {s_flags, wr_ptr};
  assign hd_flags = s_rrec[SREC_W-1 -: STAT_W];
  assign hd_eofp  = s_rrec[AW:0];
  assign hd_word  = d_rraw;

  rxf_wr_ctl #(.AW(AW)) u_wr (
    .clk, .rst_n, .in_valid, .in_data, .in_sof, .in_eof, .in_nbytes,
    .in_mac_err, .in_csum_err, .used, .d_we, .d_wdata, .s_we, .s_flags,
    .wr_ptr, .st_wptr, .ovf_pulse
  );

  rxf_ram #(.W(WORD_W), .AW(AW)) u_data (
    .clk, .we(d_we), .waddr(wr_ptr[AW-1:0]), .wdata(d_wdata),
    .raddr(rd_ptr[AW-1:0]), .rdata(d_rraw)
  );

  rxf_ram #(.W(SREC_W), .AW(AW)) u_stat (
    .clk, .we(s_we), .waddr(st_wptr[AW-1:0]), .wdata(s_wrec),
    .raddr(st_rptr[AW-1:0]), .rdata(s_rrec)
  );

  rxf_rd_ctl #(.AW(AW)) u_rd (
    .clk, .rst_n, .cfg_store_fwd, .cfg_thresh, .cfg_keep_csum, .cfg_fwd_err,
    .cfg_no_flush, .buf_avail, .wr_ptr, .st_wptr, .hd_word, .hd_flags, .hd_eofp,
    .out_ready, .rd_ptr, .st_rptr, .out_valid, .out_data, .out_sof, .out_eof,
    .out_nbytes, .out_err, .drop_pulse, .flush_pulse
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    d_we |-> used < (AW+1)'(1 << AW)); // R10
endmodule

// File: tb/tb_rxf_fwd_ctrl.sv
module tb_rxf_fwd_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_store_fwd = 0, cfg_keep_csum = 0, cfg_fwd_err = 0, cfg_no_flush = 0;
  logic [1:0] cfg_thresh = 0;
  logic buf_avail = 1, in_valid = 0, in_sof = 0, in_eof = 0, in_mac_err = 0, in_csum_err = 0;
  logic [31:0] in_data = 0;
  logic [1:0] in_nbytes = 0;
  logic out_valid, out_ready = 1, out_sof, out_eof, out_err, ovf_pulse, drop_pulse, flush_pulse;
  logic [31:0] out_data;
  logic [1:0] out_nbytes;

  int checks = 0, fails = 0;
  int rx_n = 0, n_drop = 0, n_flush = 0, n_ovf = 0, wcnt = 0, first_rd = -1, early = 0;
  logic busy = 0;
  logic [31:0] rx_data [256];
  logic rx_sof [256], rx_eof [256], rx_err [256];
  logic [1:0] rx_nb [256];

  always #5 clk = ~clk;

  rxf_fwd_ctrl dut (.*);

  always @(posedge clk) if (in_valid) wcnt = wcnt + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (drop_pulse) n_drop = n_drop + 1;
      if (flush_pulse) n_flush = n_flush + 1;
      if (ovf_pulse) n_ovf = n_ovf + 1;
      if (out_valid && first_rd < 0) first_rd = wcnt;
      if (out_valid && out_ready) begin
        if (busy) early = early + 1;
        if (rx_n < 256) begin
          rx_data[rx_n] = out_data; rx_sof[rx_n] = out_sof;
          rx_eof[rx_n] = out_eof; rx_err[rx_n] = out_err; rx_nb[rx_n] = out_nbytes;
        end
        rx_n = rx_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_rx();
    @(posedge clk); #1;
    rx_n = 0; n_drop = 0; n_flush = 0; n_ovf = 0; wcnt = 0; first_rd = -1; early = 0;
  endtask

  task automatic send(input int n, input logic [7:0] id, input logic mac,
                      input logic csum, input logic [1:0] nb);
    busy = 1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1; in_data = {id, 24'(i)}; in_sof = (i == 0); in_eof = (i == n - 1);
      in_mac_err = (i == n - 1) && mac; in_csum_err = (i == n - 1) && csum;
      in_nbytes = (i == n - 1) ? nb : 2'd0;
    end
    @(posedge clk); #1;
    in_valid = 0; in_sof = 0; in_eof = 0; in_mac_err = 0; in_csum_err = 0;
    busy = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // checks that rx holds frame id with n words starting at index base
  task automatic chk_frame(input string req, input int base, input int n,
                           input logic [7:0] id, input logic [1:0] nb, input logic err);
    int bad_data = 0, bad_tag = 0;
    for (int i = 0; i < n; i++) begin
      if (rx_data[base + i] !== {id, 24'(i)}) bad_data++;
      if (rx_sof[base + i] !== (i == 0) || rx_eof[base + i] !== (i == n - 1)) bad_tag++;
      if (rx_err[base + i] !== ((i == n - 1) && err)) bad_tag++;
    end
    chk(bad_data == 0, req, bad_data, 0);
    chk(bad_tag == 0, req, bad_tag, 0);
    chk(rx_nb[base + n - 1] == nb, "R11", int'(rx_nb[base + n - 1]), int'(nb));
  endtask

  task automatic t_reset();
    #1;
    chk(out_valid == 0 && ovf_pulse == 0 && drop_pulse == 0 && flush_pulse == 0,
        "R8", int'({out_valid, ovf_pulse, drop_pulse, flush_pulse}), 0);
    idle(3);
    chk(out_valid == 0, "R8", int'(out_valid), 0);
  endtask

  task automatic t_store_fwd();
    clear_rx(); cfg_store_fwd = 1; cfg_thresh = 0;
    send(20, 8'h11, 0, 0, 2'd3); idle(30);
    chk(early == 0, "R1", early, 0);
    chk(rx_n == 20, "R1", rx_n, 20);
    chk_frame("R11", 0, 20, 8'h11, 2'd3, 0);
  endtask

  task automatic t_cut_through();
    clear_rx(); cfg_store_fwd = 0; cfg_thresh = 2'd1;
    send(40, 8'h22, 0, 0, 2'd1); idle(20);
    chk(first_rd >= 16 && first_rd <= 18, "R2", first_rd, 16);
    chk(rx_n == 40, "R2", rx_n, 40);
    chk_frame("R2", 0, 40, 8'h22, 2'd1, 0);
  endtask

  task automatic t_drop();
    clear_rx(); cfg_store_fwd = 1; cfg_keep_csum = 0; cfg_fwd_err = 0;
    send(10, 8'h33, 1, 0, 2'd0); send(5, 8'h34, 0, 0, 2'd2); idle(20);
    chk(n_drop == 1, "R4", n_drop, 1);
    chk(rx_n == 5, "R4", rx_n, 5);
    chk_frame("R4", 0, 5, 8'h34, 2'd2, 0);
    clear_rx(); send(7, 8'h35, 0, 1, 2'd0); idle(20);
    chk(n_drop == 1 && rx_n == 0, "R4", rx_n + 100 * n_drop, 100);
  endtask

  task automatic t_keep_csum();
    clear_rx(); cfg_store_fwd = 1; cfg_keep_csum = 1; cfg_fwd_err = 0;
    send(6, 8'h44, 0, 1, 2'd1); idle(20);
    chk(rx_n == 6 && n_drop == 0, "R3", rx_n, 6);
    chk_frame("R3", 0, 6, 8'h44, 2'd1, 1);
    clear_rx(); send(6, 8'h45, 1, 1, 2'd0); idle(20);
    chk(rx_n == 0 && n_drop == 1, "R3", rx_n + 100 * n_drop, 100);
    cfg_keep_csum = 0;
  endtask

  task automatic t_fwd_err();
    clear_rx(); cfg_store_fwd = 1; cfg_fwd_err = 1;
    send(9, 8'h55, 1, 0, 2'd2); idle(20);
    chk(rx_n == 9 && n_drop == 0, "R5", rx_n, 9);
    chk_frame("R5", 0, 9, 8'h55, 2'd2, 1);
    cfg_fwd_err = 0;
  endtask

  task automatic t_flush();
    clear_rx(); cfg_store_fwd = 1; buf_avail = 0; cfg_no_flush = 0;
    send(8, 8'h66, 0, 0, 2'd0); idle(10);
    chk(n_flush == 1, "R6", n_flush, 1);
    chk(rx_n == 0, "R6", rx_n, 0);
    buf_avail = 1; idle(10);
    chk(rx_n == 0, "R6", rx_n, 0);
  endtask

  task automatic t_no_flush();
    clear_rx(); cfg_store_fwd = 1; buf_avail = 0; cfg_no_flush = 1;
    send(8, 8'h77, 0, 0, 2'd3); idle(20);
    chk(rx_n == 0 && n_flush == 0, "R7", rx_n + 100 * n_flush, 0);
    buf_avail = 1; idle(20);
    chk(rx_n == 8, "R7", rx_n, 8);
    chk_frame("R7", 0, 8, 8'h77, 2'd3, 0);
    cfg_no_flush = 0;
  endtask

  task automatic t_ct_error();
    clear_rx(); cfg_store_fwd = 0; cfg_thresh = 2'd0; cfg_keep_csum = 0; cfg_fwd_err = 0;
    send(30, 8'h88, 1, 0, 2'd0); idle(20);
    chk(first_rd >= 8 && first_rd <= 10, "R2", first_rd, 8);
    chk(rx_n == 30 && n_drop == 0, "R9", rx_n, 30);
    chk_frame("R9", 0, 30, 8'h88, 2'd0, 1);
  endtask

  task automatic t_overflow();
    clear_rx(); cfg_store_fwd = 1; out_ready = 0;
    send(70, 8'h99, 0, 0, 2'd0); idle(5);
    chk(n_ovf == 1, "R10", n_ovf, 1);
    chk(n_drop == 1 && rx_n == 0, "R10", rx_n + 100 * n_drop, 100);
    out_ready = 1;
    send(4, 8'h9A, 0, 0, 2'd1); idle(20);
    chk(rx_n == 4 && n_ovf == 1, "R10", rx_n, 4);
    chk_frame("R10", 0, 4, 8'h9A, 2'd1, 0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    rst_n = 1;
    idle(2);
    t_store_fwd();
    t_cut_through();
    t_drop();
    t_keep_csum();
    t_fwd_err();
    t_flush();
    t_no_flush();
    t_ct_error();
    t_overflow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule